// File: doc/BRIEF.md
# Line-21 Caption Byte Capture Registers

This block sits behind a line-21 data slicer. Each time the slicer finishes line 21 of a field, it presents a strobe, a field tag (field 1 for captions, field 2 for extended data), a flag saying whether a caption line was found, and the two decoded bytes. On a good line the block stores both bytes. In each stored byte, bit 7 is replaced by the result of a parity check on the byte. The block also keeps a valid flag and a ready flag for each field.

A host reads three registers through a one-cycle read strobe and an address. The two byte registers and the status register sit at consecutive addresses 0x1A, 0x1B and 0x1C. Reading the status register acknowledges the ready flags, which then stay low until fresh data arrives for their field. A field's valid flag drops when that field has gone a set number of frames without a good caption line.

Top module: `cc_capture_regs`

## Requirements
- R1: On a good line (`ln_stb`=1, `ln_ok`=1), bit 7 of each stored byte is 1 when the received byte has an odd number of ones, and 0 otherwise.
- R2: Bits 6..0 of each stored byte equal bits 6..0 of the received byte. The first byte is read at address 0x1A and the second byte at address 0x1B.
- R3: A strobe with `ln_ok`=0 leaves both byte registers and both ready flags unchanged.
- R4: The status register at address 0x1C reads {4'b0, field-2 ready, field-2 valid, field-1 ready, field-1 valid}, with bit 0 holding field-1 valid.
- R5: A good line for a field sets that field's ready flag.
- R6: A host read of address 0x1C clears every ready flag. A flag cleared this way stays low until a good line arrives for its field.
- R7: If a good line for a field arrives in the same cycle as a status read, that field's ready flag stays set.
- R8: A good line for a field sets that field's valid flag.
- R9: A field's valid flag clears on the MISS_LIMIT-th `frame_tick` (default 2) after its last good line, provided no good line for that field arrived in between. A good line in the same cycle as a tick counts as seen.
- R10: A read of any address other than 0x1A, 0x1B or 0x1C returns 0x00.
- R11: `rd_data` is registered. It shows the value addressed in the read cycle one cycle later, and it holds that value while `rd_en` is low.
- R12: After reset, every register and `rd_data` read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ln_stb | input | 1 | Slicer finished line 21 of a field |
| ln_ok | input | 1 | Caption data was found on that line |
| ln_field | input | 1 | Field tag: 0 = field 1, 1 = field 2 |
| ln_b0 | input | 8 | First decoded byte |
| ln_b1 | input | 8 | Second decoded byte |
| frame_tick | input | 1 | One-cycle pulse per frame |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Registered read data |

## Verification
A wrong parity bit or a corrupted byte register shows in the next host read of 0x1A or 0x1B, one cycle after the read strobe. A ready flag stuck high, stuck low or lost in a read-versus-arrival collision shows in the status value returned by the first status read after the fault. A miss counter that runs too fast or too slow shows when valid drops one frame tick early or late. The reference model predicts `rd_data` on every clock, so any divergence is flagged in the cycle it reaches the port.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] ADDR_B0   = 8'h1A;
  localparam logic [7:0] ADDR_B1   = 8'h1B;
  localparam logic [7:0] ADDR_STAT = 8'h1C;
  localparam int NFIELD = 2;
  // status bit positions: field f valid at 2f, ready at 2f+1
  localparam int ST_VAL = 0;
  localparam int ST_RDY = 1;
endpackage

// File: rtl/cc_parity_fmt.sv
module cc_parity_fmt
  import cc_pkg::*;
(
  input  logic [BYTE_W-1:0] raw,
  output logic [BYTE_W-1:0] fmt
);
  // odd parity over all bits: MSB set when count of ones is odd
  always_comb begin
    fmt = {^raw, raw[BYTE_W-2:0]};
  end
endmodule

// File: rtl/cc_field_track.sv
module cc_field_track #(
  parameter int MISS_LIMIT = 2,
  localparam int CNT_W = (MISS_LIMIT < 2) ? 1 : $clog2(MISS_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic frame_tick,
  input  logic clr_rdy,
  output logic valid_o,
  output logic ready_o
);
  logic [CNT_W-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      miss_q  <= '0;
    end else if (hit) begin
      valid_o <= 1'b1;
      miss_q  <= '0;
    end else if (frame_tick && valid_o) begin
      if (miss_q == CNT_W'(MISS_LIMIT - 1)) begin
        valid_o <= 1'b0;
        miss_q  <= '0;
      end else begin
        miss_q <= miss_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ready_o <= 1'b0;
    else if (hit)     ready_o <= 1'b1;
    else if (clr_rdy) ready_o <= 1'b0;
  end
endmodule

// File: rtl/cc_capture_regs.sv
module cc_capture_regs
  import cc_pkg::*;
#(
  parameter int MISS_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ln_stb,
  input  logic       ln_ok,
  input  logic       ln_field,
  input  logic [7:0] ln_b0,
  input  logic [7:0] ln_b1,
  input  logic       frame_tick,
  input  logic       rd_en,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  logic             good;
  logic [NFIELD-1:0] hit;
  logic [NFIELD-1:0] f_valid, f_ready;
  logic [7:0]        fmt_b0, fmt_b1;
  logic [7:0]        reg_b0, reg_b1;
  logic [7:0]        stat;
  logic              stat_rd;

  assign good    = ln_stb && ln_ok;
  assign stat_rd = rd_en && (rd_addr == ADDR_STAT);

  cc_parity_fmt u_p0 (.raw(ln_b0), .fmt(fmt_b0));
  cc_parity_fmt u_p1 (.raw(ln_b1), .fmt(fmt_b1));

  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    assign hit[f] = good && (ln_field == 1'(f));
    cc_field_track #(.MISS_LIMIT(MISS_LIMIT)) u_trk (
      .clk(clk), .rst(rst), .hit(hit[f]), .frame_tick(frame_tick),
      .clr_rdy(stat_rd), .valid_o(f_valid[f]), .ready_o(f_ready[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_b0 <= '0;
      reg_b1 <= '0;
    end else if (good) begin
      reg_b0 <= fmt_b0;
      reg_b1 <= fmt_b1;
    end
  end

  always_comb begin
    stat = '0;
    for (int f = 0; f < NFIELD; f++) begin
      stat[2*f+ST_VAL] = f_valid[f];
      stat[2*f+ST_RDY] = f_ready[f];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      unique case (rd_addr)
        ADDR_B0:   rd_data <= reg_b0;
        ADDR_B1:   rd_data <= reg_b1;
        ADDR_STAT: rd_data <= stat;
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cc_capture_chk.sv
module cc_capture_chk (
  input logic       clk,
  input logic       rst,
  input logic       ln_stb,
  input logic       ln_ok,
  input logic       ln_field,
  input logic [7:0] ln_b0,
  input logic [7:0] ln_b1,
  input logic       rd_en,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_data,
  input logic [1:0] f_valid,
  input logic [1:0] f_ready,
  input logic [7:0] reg_b0,
  input logic [7:0] reg_b1
);
  assert_parity_R1: assert property (@(posedge clk) disable iff (rst)
    (ln_stb && ln_ok) |=> (reg_b0[7] == ^$past(ln_b0)) && (reg_b1[7] == ^$past(ln_b1)));
  assert_low_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (ln_stb && ln_ok) |=> reg_b1[6:0] == $past(ln_b1[6:0]));
  assert_ignore_bad_R3: assert property (@(posedge clk) disable iff (rst)
    !(ln_stb && ln_ok) |=> $stable(reg_b0) && $stable(reg_b1));
  assert_ready_set_R5: assert property (@(posedge clk) disable iff (rst)
    (ln_stb && ln_ok) |=> f_ready[$past(ln_field)]);
  assert_ready_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 8'h1C && !(ln_stb && ln_ok)) |=> f_ready == 2'b00);
  assert_valid_set_R8: assert property (@(posedge clk) disable iff (rst)
    (ln_stb && ln_ok) |=> f_valid[$past(ln_field)]);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind cc_capture_regs cc_capture_chk u_chk (
  .clk(clk), .rst(rst), .ln_stb(ln_stb), .ln_ok(ln_ok), .ln_field(ln_field),
  .ln_b0(ln_b0), .ln_b1(ln_b1), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .f_valid(f_valid), .f_ready(f_ready),
  .reg_b0(reg_b0), .reg_b1(reg_b1)
);

// File: tb/sim_cc_capture_regs.sv
`timescale 1ns/1ps
module sim_cc_capture_regs;
  logic clk = 0, rst = 1;
  logic ln_stb = 0, ln_ok = 0, ln_field = 0, frame_tick = 0, rd_en = 0;
  logic [7:0] ln_b0 = 0, ln_b1 = 0, rd_addr = 0;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  cc_capture_regs u0 (.*);

  // behavioural reference model
  int mv[2], mr[2], mc[2];
  int md0 = 0, md1 = 0, exp_rd = 0;

  function automatic int fmt(input logic [7:0] b);
    return ($countones(b) % 2 == 1 ? 128 : 0) + (b % 128);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int f = 0; f < 2; f++) begin mv[f] = 0; mr[f] = 0; mc[f] = 0; end
      md0 = 0; md1 = 0; exp_rd = 0;
    end else begin
      bit good;
      good = ln_stb && ln_ok;
      if (rd_en) begin
        if (rd_addr == 8'h1A) exp_rd = md0;
        else if (rd_addr == 8'h1B) exp_rd = md1;
        else if (rd_addr == 8'h1C) exp_rd = mv[0] + 2*mr[0] + 4*mv[1] + 8*mr[1];
        else exp_rd = 0;
      end
      for (int f = 0; f < 2; f++) begin
        bit h;
        h = good && (int'(ln_field) == f);
        if (h) begin mv[f] = 1; mc[f] = 0; mr[f] = 1; end
        else begin
          if (frame_tick && mv[f] == 1) begin
            mc[f]++;
            if (mc[f] >= 2) begin mv[f] = 0; mc[f] = 0; end
          end
          if (rd_en && rd_addr == 8'h1C) mr[f] = 0;
        end
      end
      if (good) begin md0 = fmt(ln_b0); md1 = fmt(ln_b1); end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (int'(rd_data) != exp_rd) begin
        n_fail++;
        $display("FAIL R11 cycle %0d: rd_data actual %02h expected %02h", cyc, rd_data, exp_rd[7:0]);
      end
    end
  end

  task automatic chk(input logic [7:0] addr, input logic [7:0] exp, input string req);
    @(negedge clk); rd_en = 1; rd_addr = addr;
    @(negedge clk); rd_en = 0;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s addr %02h: actual %02h expected %02h", req, addr, rd_data, exp);
    end
  endtask

  task automatic line(input logic fld, input logic ok, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); ln_stb = 1; ln_ok = ok; ln_field = fld; ln_b0 = a; ln_b1 = b;
    @(negedge clk); ln_stb = 0; ln_ok = 0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(8'h1A, 8'h00, "R12"); chk(8'h1B, 8'h00, "R12"); chk(8'h1C, 8'h00, "R12");
    line(0, 1, 8'h15, 8'h03);
    chk(8'h1A, 8'h95, "R1");
    chk(8'h1B, 8'h03, "R2");
    chk(8'h1C, 8'h03, "R4 R5 R8");
    chk(8'h1C, 8'h01, "R6");
    line(0, 0, 8'hAA, 8'h55);
    chk(8'h1A, 8'h95, "R3");
    chk(8'h1C, 8'h01, "R3 ready");
    line(1, 1, 8'hFF, 8'h01);
    chk(8'h1B, 8'h81, "R1 field2");
    chk(8'h1A, 8'h7F, "R2 field2");
    chk(8'h1C, 8'h0D, "R4 field2");
    // same-cycle arrival and status read
    @(negedge clk); rd_en = 1; rd_addr = 8'h1C; ln_stb = 1; ln_ok = 1; ln_field = 0;
    ln_b0 = 8'h01; ln_b1 = 8'h02;
    @(negedge clk); rd_en = 0; ln_stb = 0; ln_ok = 0;
    n_chk++;
    if (rd_data !== 8'h05) begin n_fail++; $display("FAIL R7 pre: actual %02h expected 05", rd_data); end
    chk(8'h1C, 8'h07, "R7");
    chk(8'h1C, 8'h05, "R6 after R7");
    tick();
    chk(8'h1C, 8'h05, "R9 one tick");
    tick();
    chk(8'h1C, 8'h00, "R9 two ticks");
    line(0, 1, 8'h40, 8'h40);
    tick();
    line(0, 1, 8'h41, 8'h40);
    tick();
    chk(8'h1C, 8'h03, "R9 rearm");
    @(negedge clk); frame_tick = 1; ln_stb = 1; ln_ok = 1; ln_field = 0;
    @(negedge clk); frame_tick = 0; ln_stb = 0; ln_ok = 0;
    tick();
    chk(8'h1C, 8'h03, "R9 tick with line");
    chk(8'h10, 8'h00, "R10");
    chk(8'h1D, 8'h00, "R10");
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd_data !== 8'h00) begin n_fail++; $display("FAIL R11 hold: actual %02h expected 00", rd_data); end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule